// File: doc/BRIEF.md
# Embedded-Operation Status Flag Generator

This block supplies the byte a host sees when it reads a flash device while a byte program or an erase is running inside it. It holds a small model of the program and erase engine: a program pulse counter with a limit, and two duration timers. From the engine state it builds a status byte for each read. The top bit shows polled data. The next bit flips on every read. A third bit reports that the pulse limit was exceeded, and a fourth reports whether the sector-erase load window has closed.

A program starts from a one-cycle request that carries the byte to write and the byte the cells hold now. Each program pulse can only clear bits. After each pulse the engine checks whether the cells now equal the target. If a target bit is 1 where the cell holds 0, the cells can never match, so the pulse count passes its limit and a failure flag is latched. An erase waits until the window-expired input is high, then runs for a fixed number of cycles. A read is captured on a read strobe. It returns the status byte while an operation is active, and the external array byte otherwise.

Top module: `embop_status_gen`

## Requirements
- R1: After reset, readData is 0x00 and readIsStatus is 0. A read while no operation is active returns arrayData unchanged, with readIsStatus 0.
- R2: During a program, bit 7 of each status read is the inverse of bit 7 of the byte being programmed.
- R3: During an erase, bit 7 of each status read is 0.
- R4: Bit 6 takes opposite values on successive status reads. Once the operation ends, reads return arrayData with readIsStatus 0.
- R5: Bit 5 is 0 while an operation progresses normally. After a pulse-limit failure it is 1, bit 7 keeps the inverted value and bit 6 keeps alternating, until resetCmd is pulsed. After that, reads return arrayData.
- R6: Bit 3 is 0 during a program and during an erase whose window is still open. It is 1 once windowExpired has started the erase proper.
- R7: A program whose target needs only 1-to-0 changes of cellData completes. A program that needs any 0-to-1 change ends in the failure of R5.
- R8: During an erase, a read with addrInErase low returns arrayData with readIsStatus 0, and does not advance bit 6.
- R9: Bits 4, 2, 1 and 0 of every status read are 0.
- R10: startProg and startErase are ignored while an operation is active or failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startProg | input | 1 | One-cycle request to program a byte |
| startErase | input | 1 | One-cycle request to begin an erase |
| resetCmd | input | 1 | Reset command; clears a latched failure |
| progData | input | 8 | Byte to program, taken on startProg |
| cellData | input | 8 | Current content of the target cells, taken on startProg |
| windowExpired | input | 1 | High once the sector-load window has closed |
| readStb | input | 1 | Read strobe; result appears the next cycle |
| addrInErase | input | 1 | Read address lies in a sector being erased |
| arrayData | input | 8 | Array byte returned when status is not shown |
| readData | output | 8 | Captured read result |
| readIsStatus | output | 1 | The last read returned status rather than array data |

## Verification
Programs are run with a target that needs only cleared bits and with a target that needs a set bit. These tell a normal completion from a pulse-limit failure, and the failure must then hold until the reset command. Erases are read first with the window open and then with it closed, which separates the two values of bit 3. Erase reads are also made from addresses outside the erased sectors, which must return array data and leave the alternating bit where it was. A start request issued during a running program shows whether new commands are really ignored, because an erase would force bit 7 to 0.

// File: rtl/embop_pkg.sv
package embop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_EWAIT = 3'd2,
    ST_ERUN  = 3'd3,
    ST_FAIL  = 3'd4
  } engState_t;

  typedef struct packed {
    logic ldProg;
    logic ldErase;
    logic pulseStep;
    logic active;
    logic failed;
    logic eraseRun;
  } engCtl_t;

  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;
  localparam int FAIL_BIT = 5;
  localparam int WIN_BIT  = 3;
endpackage

// File: rtl/embop_ctrl.sv
module embop_ctrl
  import embop_pkg::*;
#(
  parameter int PULSE_LIMIT  = 6,
  parameter int PROG_CYCLES  = 3,
  parameter int ERASE_CYCLES = 20,
  localparam int CNT_W = $clog2(PULSE_LIMIT + 1),
  localparam int TMR_MAX = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES,
  localparam int TMR_W = $clog2(TMR_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startProg,
  input  logic             startErase,
  input  logic             resetCmd,
  input  logic             windowExpired,
  input  logic             cellMatch,
  output engCtl_t          ctl,
  output logic [CNT_W-1:0] pulseCnt
);
  engState_t        state;
  logic [TMR_W-1:0] tmr;
  logic             progTick;
  logic             eraseTick;
  logic             atLimit;

  assign progTick  = (state == ST_PROG) && (tmr == TMR_W'(PROG_CYCLES - 1));
  assign eraseTick = (state == ST_ERUN) && (tmr == TMR_W'(ERASE_CYCLES - 1));
  assign atLimit   = (pulseCnt == CNT_W'(PULSE_LIMIT));

  always_comb begin
    ctl           = '0;
    ctl.ldProg    = (state == ST_IDLE) && startProg;
    ctl.ldErase   = (state == ST_IDLE) && !startProg && startErase;
    ctl.pulseStep = progTick && !cellMatch && !atLimit;
    ctl.active    = (state != ST_IDLE);
    ctl.failed    = (state == ST_FAIL);
    ctl.eraseRun  = (state == ST_ERUN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tmr      <= '0;
      pulseCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          tmr      <= '0;
          pulseCnt <= '0;
          if (startProg)       state <= ST_PROG;
          else if (startErase) state <= ST_EWAIT;
        end
        ST_PROG: begin
          if (progTick) begin
            tmr <= '0;
            if (cellMatch)    state <= ST_IDLE;
            else if (atLimit) state <= ST_FAIL;
            else              pulseCnt <= pulseCnt + 1'b1;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_EWAIT: begin
          tmr <= '0;
          if (windowExpired) state <= ST_ERUN;
        end
        ST_ERUN: begin
          if (eraseTick) begin
            tmr   <= '0;
            state <= ST_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_FAIL: begin
          if (resetCmd) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/embop_dpath.sv
module embop_dpath
  import embop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  engCtl_t           ctl,
  input  logic [DATA_W-1:0] progData,
  input  logic [DATA_W-1:0] cellData,
  input  logic [DATA_W-1:0] arrayData,
  input  logic              readStb,
  input  logic              addrInErase,
  output logic              cellMatch,
  output logic [DATA_W-1:0] readData,
  output logic              readIsStatus
);
  logic [DATA_W-1:0] target;
  logic [DATA_W-1:0] cellImg;
  logic              isProg;
  logic              toggle;
  logic              statusSel;
  logic [DATA_W-1:0] statusByte;

  assign cellMatch = (cellImg == target);
  assign statusSel = ctl.active && (isProg || addrInErase);

  always_comb begin
    statusByte           = '0;
    statusByte[POLL_BIT] = isProg ? ~target[POLL_BIT] : 1'b0;
    statusByte[TOG_BIT]  = toggle;
    statusByte[FAIL_BIT] = ctl.failed;
    statusByte[WIN_BIT]  = !isProg && ctl.eraseRun;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      target       <= '0;
      cellImg      <= '0;
      isProg       <= 1'b0;
      toggle       <= 1'b0;
      readData     <= '0;
      readIsStatus <= 1'b0;
    end else begin
      if (ctl.ldProg) begin
        target  <= progData;
        cellImg <= cellData;
        isProg  <= 1'b1;
      end else if (ctl.ldErase) begin
        isProg  <= 1'b0;
      end else if (ctl.pulseStep) begin
        cellImg <= cellImg & target;
      end
      if (readStb) begin
        if (statusSel) begin
          readData     <= statusByte;
          readIsStatus <= 1'b1;
          toggle       <= ~toggle;
        end else begin
          readData     <= arrayData;
          readIsStatus <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/embop_status_gen.sv
module embop_status_gen
  import embop_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int PULSE_LIMIT  = 6,
  parameter int PROG_CYCLES  = 3,
  parameter int ERASE_CYCLES = 20,
  localparam int CNT_W = $clog2(PULSE_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startProg,
  input  logic              startErase,
  input  logic              resetCmd,
  input  logic [DATA_W-1:0] progData,
  input  logic [DATA_W-1:0] cellData,
  input  logic              windowExpired,
  input  logic              readStb,
  input  logic              addrInErase,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] readData,
  output logic              readIsStatus
);
  engCtl_t          ctl;
  logic             cellMatch;
  logic [CNT_W-1:0] pulseCnt;

  embop_ctrl #(
    .PULSE_LIMIT (PULSE_LIMIT),
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startProg    (startProg),
    .startErase   (startErase),
    .resetCmd     (resetCmd),
    .windowExpired(windowExpired),
    .cellMatch    (cellMatch),
    .ctl          (ctl),
    .pulseCnt     (pulseCnt)
  );

  embop_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .progData    (progData),
    .cellData    (cellData),
    .arrayData   (arrayData),
    .readStb     (readStb),
    .addrInErase (addrInErase),
    .cellMatch   (cellMatch),
    .readData    (readData),
    .readIsStatus(readIsStatus)
  );
endmodule

// File: rtl/embop_chk.sv
module embop_chk
  import embop_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PULSE_LIMIT = 6,
  localparam int CNT_W = $clog2(PULSE_LIMIT + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              resetCmd,
  input logic              readStb,
  input logic [DATA_W-1:0] readData,
  input logic              readIsStatus,
  input engCtl_t           ctl,
  input logic [CNT_W-1:0]  pulseCnt
);
  // R9: unused status positions stay low
  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    readIsStatus |-> (readData[4] == 1'b0 && readData[2:0] == 3'b000));

  // R3: the window bit only appears for erase, which polls as 0
  p_erase_poll_r3: assert property (@(posedge clk) disable iff (!rstN)
    (readIsStatus && readData[WIN_BIT]) |-> !readData[POLL_BIT]);

  // R5: failure persists until reset command
  p_fail_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.failed && !resetCmd) |=> ctl.failed);

  // R5: a fresh status read reporting failure came from the failed state
  p_fail_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(readStb) && readIsStatus && readData[FAIL_BIT]) |-> $past(ctl.failed));

  // R7: the pulse counter never passes its limit
  p_pulse_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= CNT_W'(PULSE_LIMIT));

  // R4: with no operation active, a read returns array data
  p_idle_array_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.active && readStb) |=> !readIsStatus);
endmodule

bind embop_status_gen embop_chk #(
  .DATA_W     (DATA_W),
  .PULSE_LIMIT(PULSE_LIMIT)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .resetCmd    (resetCmd),
  .readStb     (readStb),
  .readData    (readData),
  .readIsStatus(readIsStatus),
  .ctl         (ctl),
  .pulseCnt    (pulseCnt)
);

// File: tb/embop_status_gen_test.sv
module embop_status_gen_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startProg = 1'b0, startErase = 1'b0, resetCmd = 1'b0;
  logic [7:0] progData = '0, cellData = '0, arrayData = '0;
  logic       windowExpired = 1'b0, readStb = 1'b0, addrInErase = 1'b0;
  logic [7:0] readData;
  logic       readIsStatus;

  int checks = 0;
  int errors = 0;
  logic expTog = 1'b0;

  always #4 clk = ~clk;

  embop_status_gen uut (
    .clk(clk), .rstN(rstN), .startProg(startProg), .startErase(startErase),
    .resetCmd(resetCmd), .progData(progData), .cellData(cellData),
    .windowExpired(windowExpired), .readStb(readStb), .addrInErase(addrInErase),
    .arrayData(arrayData), .readData(readData), .readIsStatus(readIsStatus)
  );

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doRead(input logic inSec, input logic [7:0] arr);
    @(negedge clk);
    addrInErase = inSec;
    arrayData   = arr;
    readStb     = 1'b1;
    @(negedge clk);
    readStb     = 1'b0;
  endtask

  // status read with expected flags (bit 6 taken from the tracked toggle)
  task automatic statusRead(input string tag, input logic inSec, input logic [7:0] base);
    doRead(inSec, 8'h11);
    check(tag, {readIsStatus, readData}, {1'b1, base | {1'b0, expTog, 6'b0}});
    expTog = ~expTog;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic pollDone(input string tag, input logic inSec, input logic [7:0] base,
                          input logic [7:0] arr, input int maxReads);
    bit done = 0;
    for (int i = 0; i < maxReads && !done; i++) begin
      doRead(inSec, arr);
      if (readIsStatus) begin
        check(tag, {1'b1, readData}, {1'b1, base | {1'b0, expTog, 6'b0}});
        expTog = ~expTog;
      end else begin
        done = 1;
      end
    end
    check({tag, " done"}, {readIsStatus, readData}, {1'b0, arr});
  endtask

  task automatic testReset;
    check("R1 reset", {readIsStatus, readData}, 9'h000);
    doRead(1'b0, 8'h3C);
    check("R1 idle read", {readIsStatus, readData}, {1'b0, 8'h3C});
  endtask

  task automatic testProgram;
    progData = 8'h5A; cellData = 8'hFF;
    pulse(startProg);
    statusRead("R2 prog poll", 1'b0, 8'h80);
    statusRead("R4 prog toggle", 1'b0, 8'h80);
    pollDone("R7 prog complete", 1'b0, 8'h80, 8'h5A, 40);
    progData = 8'hC3; cellData = 8'hFF;
    pulse(startProg);
    statusRead("R2 prog bit7 one", 1'b0, 8'h00);
    pollDone("R4 prog stop", 1'b0, 8'h00, 8'hC3, 40);
  endtask

  task automatic testIgnoreStart;
    progData = 8'h12; cellData = 8'hF7;
    pulse(startProg);
    pulse(startErase);
    statusRead("R10 erase ignored", 1'b0, 8'h80);
    pollDone("R10 prog still ends", 1'b0, 8'h80, 8'h12, 40);
  endtask

  task automatic testFail;
    progData = 8'h70; cellData = 8'h0F;
    pulse(startProg);
    statusRead("R5 no fail yet", 1'b0, 8'h80);
    for (int i = 0; i < 30; i++) begin
      doRead(1'b0, 8'h44);
      check("R5 status held", {readIsStatus, readData[7:6]}, {1'b1, 1'b1, expTog});
      expTog = ~expTog;
    end
    statusRead("R7 impossible prog fails", 1'b0, 8'hA0);
    pulse(startErase);
    statusRead("R10 erase ignored in fail", 1'b0, 8'hA0);
    statusRead("R5 toggle in fail", 1'b0, 8'hA0);
    pulse(resetCmd);
    doRead(1'b0, 8'h66);
    check("R5 reset returns array", {readIsStatus, readData}, {1'b0, 8'h66});
  endtask

  task automatic testErase;
    windowExpired = 1'b0;
    pulse(startErase);
    statusRead("R3 erase window open", 1'b1, 8'h00);
    doRead(1'b0, 8'h9D);
    check("R8 outside sector", {readIsStatus, readData}, {1'b0, 8'h9D});
    statusRead("R8 toggle not advanced", 1'b1, 8'h00);
    statusRead("R6 window open bit3", 1'b1, 8'h00);
    @(negedge clk); windowExpired = 1'b1;
    @(negedge clk);
    statusRead("R6 erase running bit3", 1'b1, 8'h08);
    pollDone("R4 erase complete", 1'b1, 8'h08, 8'hFF, 40);
    windowExpired = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testProgram();
    testIgnoreStart();
    testFail();
    testErase();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule